// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block sits between a synchronous host and an external asynchronous static RAM of 131,072 bytes. The host gives a single request made of a read/write flag, a 17-bit address and one byte of write data. The controller then runs the memory's control lines through a fixed sequence of clock-counted phases. It returns a one-cycle completion strobe and, for a read, the captured byte. All memory-side outputs come from registers. The data bus is split into an output byte, an input byte and a drive-enable, and the pad ring joins them into a tristate bus.

Each timing minimum of the memory, given in nanoseconds, is turned into a whole number of clocks: the time is rounded up to full clock periods and one more cycle is added as capture margin. A read holds output enable low with write enable high until the access count runs out. The byte is captured on that edge, and the memory is then released. A write keeps output enable high for the whole cycle. It leaves one clock of address set-up before write enable falls, turns the data drivers on one clock after that fall, and turns them off one clock after the rise. Between operations the controller always spends at least one cycle with the memory deselected, so the address can change legally.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, both chip enables are inactive (`sram_ce_n`=1, `sram_ce`=0), `sram_we_n`=1, `sram_oe_n`=1, `sram_dq_oe`=0, `busy`=0 and `done`=0.
- R2: The memory is selected only while an accepted request is in progress (`busy`=1), and `sram_ce_n` is always the inverse of `sram_ce`.
- R3: A read holds `sram_oe_n`=0 and `sram_we_n`=1 while selected. It captures `sram_dq_in` on the edge that closes an access count of RD_CYC cycles (12 at the default 5 ns clock), so `done` is seen 13 cycles after the accepting edge with `rd_data` holding the byte.
- R4: In a write `sram_oe_n` stays 1, and `sram_we_n` is low only while the memory is selected, for exactly WE_LOW consecutive cycles (10 at default timing).
- R5: `sram_addr` does not change while the memory is selected.
- R6: `sram_dq_oe` rises one cycle after `sram_we_n` falls and falls one cycle after `sram_we_n` rises. It is never high while `sram_oe_n`=0.
- R7: `sram_we_n` falls one cycle after the enables become active, and the enables go inactive one cycle after `sram_we_n` rises, so a write also completes 13 cycles after acceptance.
- R8: `done` is a one-cycle pulse, `busy` is 0 on the cycle after it, and the memory stays deselected for at least two cycles between two operations.
- R9: `req_valid` is ignored while `busy`=1: no second operation starts and the memory contents are left unchanged.
- R10: The byte written at an address is the byte that a later read of that address returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present; taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | Operation in progress, requests ignored |
| done | output | 1 | One-cycle completion strobe |
| rd_data | output | 8 | Byte captured by the last read |
| sram_addr | output | 17 | Memory address lines |
| sram_ce_n | output | 1 | Active-low chip enable |
| sram_ce | output | 1 | Active-high chip enable |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dq_out | output | 8 | Byte driven toward the memory |
| sram_dq_oe | output | 1 | Data driver enable for the tristate pad |
| sram_dq_in | input | 8 | Byte read back from the memory pins |

## Verification
The hardest case to reach from the ports is a read that captures too early. An ideal memory model shows the right byte at once and would hide such a fault. The bench's memory model therefore returns a poison byte until output enable has been low for the full count, so an access phase that is one cycle short shows up as a wrong byte. A second hard case is a request that arrives while an operation is in progress. A directed test raises a write request in the middle of a read and then shows at the ports that the memory was neither reselected nor modified. Random traffic over a small address pool, with requests issued the moment the controller frees up, covers back-to-back spacing and write-then-read data.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and timing helpers for the static RAM bus controller.
package sram_ctrl_pkg;

    // Controller phases; each one is a registered state of the sequencer.
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ACC   = 3'd1,
        ST_WR_SETUP = 3'd2,
        ST_WR_PULSE = 3'd3,
        ST_WR_RECOV = 3'd4,
        ST_GAP      = 3'd5
    } ctrl_state_t;

    // Whole clocks covering t_ns, plus one cycle of capture margin.
    function automatic int ns_to_cycles(input int t_ns, input int clk_ns);
        return (t_ns + clk_ns - 1) / clk_ns + 1;
    endfunction

    // Larger of two cycle counts.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Down-counter that measures the length of one controller phase.
// Assumes: load takes priority; the count stops at zero and reports expiry.
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Load a new phase length or count the running one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_data_pad.sv
// Data-path registers: write byte, driver enable and read capture.
// Assumes: the sequencer never sets and clears the driver in the same cycle.
module sram_data_pad #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_load,
    input  logic [DATA_W-1:0] wdata,
    input  logic              drv_set,
    input  logic              drv_clr,
    input  logic              rd_capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic [DATA_W-1:0] rd_data
);
    // Hold the byte to be written for the whole write cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dq_out <= '0;
        else if (wr_load)
            dq_out <= wdata;
    end

    // Turn the data drivers on and off at the sequencer's command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dq_oe <= 1'b0;
        else if (drv_set)
            dq_oe <= 1'b1;
        else if (drv_clr)
            dq_oe <= 1'b0;
    end

    // Capture the memory byte on the edge that ends the access count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_capture)
            rd_data <= dq_in;
    end
endmodule

// File: rtl/sram_bus_ctrl.sv
// Sequencer that runs one read or write on an asynchronous static RAM.
// Assumes: the host holds its request fields while req_valid is high and
// idle; the timing parameters are minimums of the attached memory grade.
module sram_bus_ctrl #(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 5,
    parameter int T_RC_NS   = 55,
    parameter int T_AA_NS   = 55,
    parameter int T_OE_NS   = 30,
    parameter int T_WC_NS   = 55,
    parameter int T_AW_NS   = 50,
    parameter int T_WP_NS   = 40,
    parameter int T_DW_NS   = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_ce,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);
    import sram_ctrl_pkg::*;

    // Read access: cover address, enable and output-enable access times.
    localparam int RD_CYC = max2(max2(ns_to_cycles(T_RC_NS, CLK_NS),
                                      ns_to_cycles(T_AA_NS, CLK_NS)),
                                 ns_to_cycles(T_OE_NS, CLK_NS));
    // Write-enable low time: pulse width, data set-up after the one-cycle
    // driver delay, address-to-end (one set-up cycle precedes) and cycle time
    // (set-up and recovery cycles surround it).
    localparam int WE_LOW = max2(max2(ns_to_cycles(T_WP_NS, CLK_NS),
                                      ns_to_cycles(T_DW_NS, CLK_NS) + 1),
                                 max2(ns_to_cycles(T_AW_NS, CLK_NS) - 1,
                                      ns_to_cycles(T_WC_NS, CLK_NS) - 2));
    localparam int CNT_W  = $clog2(max2(RD_CYC, WE_LOW) + 1);

    ctrl_state_t       state_q;
    logic              sel_q;
    logic              we_n_q;
    logic              oe_n_q;
    logic              done_q;
    logic [ADDR_W-1:0] addr_q;

    logic              accept;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_exp;
    logic              rd_capture;
    logic              drv_set;
    logic              drv_clr;

    // Decode the phase events that steer the timer and the data path.
    always_comb begin
        accept     = (state_q == ST_IDLE) && req_valid;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        if (accept && !req_write) begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(RD_CYC - 1);
        end else if (state_q == ST_WR_SETUP) begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(WE_LOW - 1);
        end
        rd_capture = (state_q == ST_RD_ACC) && tmr_exp;
        drv_set    = (state_q == ST_WR_PULSE) && !we_n_q && !sram_dq_oe;
        drv_clr    = (state_q == ST_WR_RECOV);
    end

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    sram_data_pad #(.DATA_W(DATA_W)) u_pad (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_load    (accept && req_write),
        .wdata      (req_wdata),
        .drv_set    (drv_set),
        .drv_clr    (drv_clr),
        .rd_capture (rd_capture),
        .dq_in      (sram_dq_in),
        .dq_out     (sram_dq_out),
        .dq_oe      (sram_dq_oe),
        .rd_data    (rd_data)
    );

    // Step through the phases and register every memory control line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= 1'b0;
            we_n_q  <= 1'b1;
            oe_n_q  <= 1'b1;
            done_q  <= 1'b0;
            addr_q  <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    addr_q  <= req_addr;
                    sel_q   <= 1'b1;
                    oe_n_q  <= req_write;
                    state_q <= req_write ? ST_WR_SETUP : ST_RD_ACC;
                end
                ST_RD_ACC: if (tmr_exp) begin
                    sel_q   <= 1'b0;
                    oe_n_q  <= 1'b1;
                    done_q  <= 1'b1;
                    state_q <= ST_GAP;
                end
                ST_WR_SETUP: begin
                    we_n_q  <= 1'b0;
                    state_q <= ST_WR_PULSE;
                end
                ST_WR_PULSE: if (tmr_exp) begin
                    we_n_q  <= 1'b1;
                    state_q <= ST_WR_RECOV;
                end
                ST_WR_RECOV: begin
                    sel_q   <= 1'b0;
                    done_q  <= 1'b1;
                    state_q <= ST_GAP;
                end
                ST_GAP:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;
    assign sram_addr = addr_q;
    assign sram_ce_n = !sel_q;
    assign sram_ce   = sel_q;
    assign sram_we_n = we_n_q;
    assign sram_oe_n = oe_n_q;
endmodule

// File: rtl/sram_bus_ctrl_chk.sv
// Protocol checker for the static RAM bus controller, bound to every instance.
module sram_bus_ctrl_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_ce_n,
    input logic              sram_ce,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic              sram_dq_oe
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (sram_ce_n && !sram_ce && sram_we_n && sram_oe_n && !sram_dq_oe && !busy && !done)); // R1
    AST_SELECT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_ce_n |-> busy); // R2
    AST_WRITE_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (sram_oe_n && !sram_ce_n && sram_ce)); // R4
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr)); // R5
    AST_DRIVE_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> (!sram_we_n && !$past(sram_we_n))); // R6
    AST_DRIVE_NOT_READING: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_ce_n) |-> !$past(busy)); // R9
endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .sram_addr  (sram_addr),
    .sram_ce_n  (sram_ce_n),
    .sram_ce    (sram_ce),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_bus_ctrl_tb.sv
// Bench: memory model with a poisoned access window, directed corners and
// seeded random traffic checked against a shadow copy kept by the bench.
module sram_bus_ctrl_tb;
    localparam int AW       = 17;
    localparam int DW       = 8;
    localparam int OP_LAT   = 13;  // accept edge to done, read and write
    localparam int WE_LEN   = 10;  // write-enable low cycles
    localparam int ACC_MIN  = 12;  // output-enable low samples before valid data

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          busy, done;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] sram_addr;
    logic          sram_ce_n, sram_ce, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [DW-1:0] sram_dq_out;
    logic [DW-1:0] sram_dq_in = 8'hEE;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [DW-1:0] model_mem  [int];
    logic [DW-1:0] shadow_mem [int];

    always #2.5 clk = ~clk;

    sram_bus_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
        .sram_ce(sram_ce), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    function automatic logic [DW-1:0] init_pat(input logic [AW-1:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
    endfunction

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
        return shadow_mem.exists(int'(a)) ? shadow_mem[int'(a)] : init_pat(a);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Memory model and port monitor, sampled on the falling edge.
    logic          p_we_n = 1'b1, p_dq_oe = 1'b0, p_done = 1'b0, p_sel = 1'b0;
    logic [AW-1:0] p_addr = '0;
    int            we_len = 0, oe_cnt = 0, desel_len = 0, wr_events = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!sram_ce_n && p_sel && sram_addr != p_addr)
                chk(0, "R5 address moved while selected", int'(sram_addr), int'(p_addr));
            if (sram_ce_n != !sram_ce || (!sram_ce_n && !busy))
                chk(0, "R2 enable pair or select outside busy", int'(sram_ce_n), int'(!busy));
            if (!sram_we_n) we_len++;
            if (sram_dq_oe && !p_dq_oe)
                chk(we_len == 2, "R6 drivers on one cycle after write enable falls", we_len, 2);
            if (!sram_dq_oe && p_dq_oe)
                chk(sram_we_n && p_we_n, "R6 drivers off one cycle after write enable rises", int'(p_we_n), 1);
            if (sram_we_n && !p_we_n) begin
                chk(we_len == WE_LEN, "R4 write enable low length", we_len, WE_LEN);
                chk(!sram_ce_n && sram_dq_oe, "R6 data driven at end of write", int'(sram_dq_oe), 1);
                model_mem[int'(sram_addr)] = sram_dq_oe ? sram_dq_out : 8'hEE;
                wr_events++;
                we_len = 0;
            end
            if (p_done)
                chk(!busy, "R8 busy low after done", int'(busy), 0);
            if (!sram_ce_n && !p_sel)
                chk(desel_len >= 2, "R8 deselected gap between operations", desel_len, 2);
            desel_len = sram_ce_n ? desel_len + 1 : 0;
            oe_cnt = (!sram_ce_n && !sram_oe_n) ? oe_cnt + 1 : 0;
            if (oe_cnt >= ACC_MIN)
                sram_dq_in <= model_mem.exists(int'(sram_addr)) ? model_mem[int'(sram_addr)]
                                                              : init_pat(sram_addr);
            else
                sram_dq_in <= 8'hEE;
        end
        p_we_n  = sram_we_n;
        p_dq_oe = sram_dq_oe;
        p_done  = done;
        p_sel   = !sram_ce_n;
        p_addr  = sram_addr;
    end

    // One operation: request, acceptance, latency and result.
    task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int lat = 0;
        int wait_n = 0;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        do begin @(negedge clk); wait_n++; end while (!busy && wait_n < 20);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            if (wr) chk(sram_oe_n, "R4 output enable high during write", int'(sram_oe_n), 1);
            else    chk(!sram_oe_n && sram_we_n, "R3 read control levels", int'(sram_oe_n), 0);
            @(negedge clk); lat++;
        end
        if (wr) begin
            chk(lat == OP_LAT, "R7 write completion latency", lat, OP_LAT);
            shadow_mem[int'(a)] = d;
        end else begin
            chk(lat == OP_LAT, "R3 read completion latency", lat, OP_LAT);
            chk(rd_data == exp_read(a), "R10 read data", int'(rd_data), int'(exp_read(a)));
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            chk(0, "watchdog expired", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'hC0FFEE);
        repeat (3) @(negedge clk);
        chk(sram_ce_n && !sram_ce && sram_we_n && sram_oe_n && !sram_dq_oe && !busy && !done,
            "R1 reset state", int'({sram_ce_n, sram_ce, sram_we_n, sram_oe_n, sram_dq_oe, busy, done}),
            7'b1011000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sram_ce_n && sram_we_n && sram_oe_n && !busy, "R1 first cycle after reset",
            int'(busy), 0);

        // Directed corners: lowest and highest address, untouched reads.
        do_op(0, 17'h00000, 8'h00);
        do_op(1, 17'h00000, 8'hA5);
        do_op(1, 17'h1FFFF, 8'hFF);
        do_op(0, 17'h1FFFF, 8'h00);
        do_op(0, 17'h00000, 8'h00);
        do_op(1, 17'h0AAAA, 8'h00);
        do_op(0, 17'h0AAAA, 8'h00);

        // R9: a write request during a read must be ignored.
        req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h00123;
        do @(negedge clk); while (!busy);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00456; req_wdata = 8'h3C;
        repeat (2) @(negedge clk);
        chk(sram_addr == 17'h00123 && sram_we_n, "R9 request during busy ignored",
            int'(sram_addr), 17'h00123);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        chk(rd_data == exp_read(17'h00123), "R9 interrupted read data", int'(rd_data),
            int'(exp_read(17'h00123)));
        repeat (4) begin
            @(negedge clk);
            chk(sram_ce_n && !busy, "R9 no second operation started", int'(sram_ce_n), 1);
        end
        do_op(0, 17'h00456, 8'h00);

        // Seeded random traffic over a small pool, issued back to back.
        for (int i = 0; i < 300; i++) begin
            logic [AW-1:0] a;
            a = {9'(($urandom % 3 == 0) ? 9'h1FF : 9'h000), 4'h0, 4'($urandom % 16)};
            do_op(bit'($urandom % 2), a, 8'($urandom));
        end
        chk(wr_events > 0, "R10 model saw writes", wr_events, 1);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule